// File: doc/BRIEF.md
# Frequency-Filtered Placement for a Direct-Mapped Cache with Bypass Buffer

This block makes the placement decision for a direct-mapped cache that is paired with a small fully associative bypass buffer. Each request carries a line address. The block searches the tags of both structures in the same cycle. A hit in either one is reported as a hit. On a miss it chooses where the new line goes.

The choice is driven by a table of small saturating counters. Each counter covers a block of memory that holds several cache lines. Every access raises the counter of the requested block. Each miss that meets an occupied frame lowers the counter of the resident line's block. A new line takes over an occupied frame only when its block's counter is strictly greater than the resident block's counter. A line that loses the comparison goes into the bypass buffer, which replaces its entries in FIFO order. The block holds tag state only: the data arrays and the memory side belong to the surrounding cache.

The result of each request appears one clock later as one of four outcome codes.

Top module: `freq_bypass_filter`

## Requirements
- R1: A response pulse (`rsp_valid` high for one cycle) follows every request cycle exactly one clock later. No response appears in a cycle that follows a cycle without a request.
- R2: `rsp_kind` encodes the outcome as 0 = hit in the direct-mapped array, 1 = hit in the bypass buffer, 2 = miss with the line placed in the direct-mapped array, 3 = miss with the line placed in the bypass buffer.
- R3: A request hits the direct-mapped array when the frame at index `req_line % DM_LINES` is valid and holds the same line address.
- R4: A request hits the bypass buffer when a valid buffer entry holds the same line address. A line is never resident in both structures at once.
- R5: A miss whose frame is empty places the line in that frame without any counter comparison.
- R6: A miss whose frame is occupied places the new line in the frame, evicting the resident line, only if the counter of the requested block is strictly greater than the counter of the resident line's block. Otherwise the line goes to the bypass buffer. The comparison uses the counter values from before this request's update.
- R7: Each request raises the counter of the requested block (block = `req_line / BLOCK_LINES`) by one, saturating at 2^CNT_W-1.
- R8: Each miss that meets an occupied frame lowers the counter of the resident line's block by one, saturating at 0. When the raise and the lower fall on the same counter entry, that entry is left unchanged.
- R9: The bypass buffer holds BUF_LINES lines. When it is full, a new placement overwrites the oldest entry.
- R10: After reset both structures are empty and all counters are zero, so the first request to any frame reports code 2.
- R11: The counter table has no tag. It is indexed by block number modulo CNT_ENTRIES, so blocks that alias share one counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_line | input | LINE_AW (27) | Line address of the lookup |
| rsp_valid | output | 1 | Outcome of the previous cycle's lookup is valid |
| rsp_kind | output | 2 | Outcome code, encoded as in R2 |

## Verification
All state updates and the registered outcome are committed at the same clock edge that accepts a request. The outcome code is therefore due one cycle after the request, and the next request already sees the updated tags and counters. The bench drives a request on a falling edge and computes the expected outcome from its own model at that moment. It then compares `rsp_valid` and `rsp_kind` on the next falling edge, so every clock yields one comparison, including idle cycles, which must show no response. Directed sequences cover saturation, ties, counter aliasing and buffer wrap. They are followed by a long stream of conflicting addresses.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  typedef enum logic [1:0] {
    RSP_MAIN_HIT  = 2'd0,
    RSP_BUF_HIT   = 2'd1,
    RSP_FILL_MAIN = 2'd2,
    RSP_FILL_BUF  = 2'd3
  } rsp_kind_e;
endpackage

// File: rtl/fbf_counter_table.sv
module fbf_counter_table #(
  parameter int CNT_ENTRIES = 1024,
  parameter int CNT_W       = 4,
  localparam int CIDX_W     = $clog2(CNT_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CIDX_W-1:0] rd_a_idx,
  input  logic [CIDX_W-1:0] rd_b_idx,
  output logic [CNT_W-1:0]  rd_a_cnt,
  output logic [CNT_W-1:0]  rd_b_cnt,
  input  logic              up_en,
  input  logic [CIDX_W-1:0] up_idx,
  input  logic              dn_en,
  input  logic [CIDX_W-1:0] dn_idx
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_all [CNT_ENTRIES];

  for (genvar i = 0; i < CNT_ENTRIES; i++) begin : g_cnt
    logic             up, dn, ce;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign up = up_en && (up_idx == CIDX_W'(i));
    assign dn = dn_en && (dn_idx == CIDX_W'(i));
    assign ce = up ^ dn;

    always_comb begin
      cnt_d = cnt_q;
      if (up && cnt_q != CNT_MAX)
        cnt_d = cnt_q + 1'b1;
      else if (dn && cnt_q != '0)
        cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt_q <= '0;
      else if (ce)
        cnt_q <= cnt_d;
    end

    assign cnt_all[i] = cnt_q;
  end

  assign rd_a_cnt = cnt_all[rd_a_idx];
  assign rd_b_cnt = cnt_all[rd_b_idx];
endmodule

// File: rtl/fbf_main_tags.sv
module fbf_main_tags #(
  parameter int DM_LINES = 64,
  parameter int TAG_W    = 21,
  localparam int IDX_W   = $clog2(DM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic             vic_valid,
  output logic [TAG_W-1:0] vic_tag,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag
);
  logic             vld_all [DM_LINES];
  logic [TAG_W-1:0] tag_all [DM_LINES];

  for (genvar i = 0; i < DM_LINES; i++) begin : g_frame
    logic             we;
    logic             vld_q;
    logic [TAG_W-1:0] tag_q;

    assign we = wr_en && (lk_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        vld_q <= 1'b0;
      else if (we)
        vld_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (we)
        tag_q <= wr_tag;
    end

    assign vld_all[i] = vld_q;
    assign tag_all[i] = tag_q;
  end

  assign vic_valid = vld_all[lk_idx];
  assign vic_tag   = tag_all[lk_idx];
  assign lk_hit    = vic_valid && (vic_tag == lk_tag);
endmodule

// File: rtl/fbf_bypass_buf.sv
module fbf_bypass_buf #(
  parameter int BUF_LINES = 32,
  parameter int LINE_AW   = 27,
  localparam int PTR_W    = $clog2(BUF_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINE_AW-1:0] lk_line,
  output logic               lk_hit,
  input  logic               wr_en
);
  logic [PTR_W-1:0]     ptr_q, ptr_d;
  logic [BUF_LINES-1:0] match;

  always_comb begin
    ptr_d = ptr_q + 1'b1;
    if (ptr_q == PTR_W'(BUF_LINES - 1))
      ptr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (wr_en)
      ptr_q <= ptr_d;
  end

  for (genvar i = 0; i < BUF_LINES; i++) begin : g_ent
    logic               we;
    logic               vld_q;
    logic [LINE_AW-1:0] line_q;

    assign we = wr_en && (ptr_q == PTR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        vld_q <= 1'b0;
      else if (we)
        vld_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (we)
        line_q <= lk_line;
    end

    assign match[i] = vld_q && (line_q == lk_line);
  end

  assign lk_hit = |match;
endmodule

// File: rtl/freq_bypass_filter.sv
module freq_bypass_filter
  import fbf_pkg::*;
#(
  parameter int LINE_AW     = 27,
  parameter int BLOCK_LINES = 32,
  parameter int DM_LINES    = 64,
  parameter int BUF_LINES   = 32,
  parameter int CNT_ENTRIES = 1024,
  parameter int CNT_W       = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [LINE_AW-1:0] req_line,
  output logic               rsp_valid,
  output logic [1:0]         rsp_kind
);
  localparam int IDX_W  = $clog2(DM_LINES);
  localparam int TAG_W  = LINE_AW - IDX_W;
  localparam int BSH    = $clog2(BLOCK_LINES);
  localparam int CIDX_W = $clog2(CNT_ENTRIES);

  logic rst_m, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m  <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_m  <= 1'b1;
      rst_sn <= rst_m;
    end
  end

  logic [IDX_W-1:0]   req_idx;
  logic [TAG_W-1:0]   req_tag;
  logic               main_hit, buf_hit, vic_valid;
  logic [TAG_W-1:0]   vic_tag;
  logic [LINE_AW-1:0] vic_line;
  logic [CIDX_W-1:0]  req_cidx, vic_cidx;
  logic [CNT_W-1:0]   req_cnt, vic_cnt;
  rsp_kind_e          kind_d, kind_q;
  logic               any_hit, fill_main, fill_buf, dn_en;
  logic               rsp_valid_q;

  assign req_idx  = req_line[IDX_W-1:0];
  assign req_tag  = req_line[LINE_AW-1:IDX_W];
  assign vic_line = {vic_tag, req_idx};
  assign req_cidx = CIDX_W'(req_line >> BSH);
  assign vic_cidx = CIDX_W'(vic_line >> BSH);

  fbf_main_tags #(.DM_LINES(DM_LINES), .TAG_W(TAG_W)) u_main (
    .clk(clk), .rst_n(rst_sn),
    .lk_idx(req_idx), .lk_tag(req_tag), .lk_hit(main_hit),
    .vic_valid(vic_valid), .vic_tag(vic_tag),
    .wr_en(fill_main), .wr_tag(req_tag)
  );

  fbf_bypass_buf #(.BUF_LINES(BUF_LINES), .LINE_AW(LINE_AW)) u_buf (
    .clk(clk), .rst_n(rst_sn),
    .lk_line(req_line), .lk_hit(buf_hit), .wr_en(fill_buf)
  );

  fbf_counter_table #(.CNT_ENTRIES(CNT_ENTRIES), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sn),
    .rd_a_idx(req_cidx), .rd_b_idx(vic_cidx),
    .rd_a_cnt(req_cnt), .rd_b_cnt(vic_cnt),
    .up_en(req_valid), .up_idx(req_cidx),
    .dn_en(dn_en), .dn_idx(vic_cidx)
  );

  always_comb begin
    if (main_hit)
      kind_d = RSP_MAIN_HIT;
    else if (buf_hit)
      kind_d = RSP_BUF_HIT;
    else if (!vic_valid || (req_cnt > vic_cnt))
      kind_d = RSP_FILL_MAIN;
    else
      kind_d = RSP_FILL_BUF;
  end

  assign any_hit   = main_hit || buf_hit;
  assign fill_main = req_valid && (kind_d == RSP_FILL_MAIN);
  assign fill_buf  = req_valid && (kind_d == RSP_FILL_BUF);
  assign dn_en     = req_valid && !any_hit && vic_valid;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)
      rsp_valid_q <= 1'b0;
    else
      rsp_valid_q <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)
      kind_q <= RSP_MAIN_HIT;
    else if (req_valid)
      kind_q <= kind_d;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_kind  = kind_q;
endmodule

// File: rtl/fbf_chk.sv
module fbf_chk #(
  parameter int LINE_AW = 27
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [LINE_AW-1:0] req_line,
  input logic               rsp_valid,
  input logic [1:0]         rsp_kind,
  input logic               main_hit,
  input logic               buf_hit
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R4
  disjoint_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !(main_hit && buf_hit));

  // R3
  repeat_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid) && req_line == $past(req_line))
      |=> (rsp_kind == 2'd0 || rsp_kind == 2'd1));
endmodule

bind freq_bypass_filter fbf_chk #(.LINE_AW(LINE_AW)) u_chk (
  .clk(clk), .rst_n(rst_sn),
  .req_valid(req_valid), .req_line(req_line),
  .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
  .main_hit(main_hit), .buf_hit(buf_hit)
);

// File: tb/freq_bypass_filter_tb.sv
`timescale 1ns/1ps
module freq_bypass_filter_tb;
  localparam int LAW = 27;
  localparam int DM = 64;
  localparam int BL = 32;
  localparam int NB = 32;
  localparam int NC = 1024;
  localparam int CMAX = 15;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           req_valid;
  logic [LAW-1:0] req_line;
  logic           rsp_valid;
  logic [1:0]     rsp_kind;

  always #2 clk = ~clk;

  freq_bypass_filter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind)
  );

  int          n_vec = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  int unsigned m_line [DM];
  bit          m_vld  [DM];
  int          cnt    [NC];
  int unsigned bq [$];

  function automatic int blk(int unsigned ln);
    return int'((ln / BL) % NC);
  endfunction

  task automatic model(input int unsigned ln, output int k, output string tg);
    int  ix = int'(ln % DM);
    bit  inb = 1'b0;
    int  ri, vi;
    foreach (bq[j]) if (bq[j] == ln) inb = 1'b1;
    ri = blk(ln);
    vi = blk(m_line[ix]);
    if (m_vld[ix] && m_line[ix] == ln) begin k = 0; tg = "R3"; end
    else if (inb) begin k = 1; tg = "R4"; end
    else if (!m_vld[ix]) begin k = 2; tg = "R5"; end
    else begin
      k  = (cnt[ri] > cnt[vi]) ? 2 : 3;
      tg = "R6";
    end
    if (k >= 2 && m_vld[ix]) begin
      if (ri != vi) begin
        if (cnt[ri] < CMAX) cnt[ri]++;
        if (cnt[vi] > 0) cnt[vi]--;
      end
    end else if (cnt[ri] < CMAX) cnt[ri]++;
    if (k == 2) begin m_line[ix] = ln; m_vld[ix] = 1'b1; end
    if (k == 3) begin
      bq.push_back(ln);
      if (bq.size() > NB) void'(bq.pop_front());
    end
  endtask

  task automatic step(input bit v, input int unsigned ln, input string tag);
    int    k = 0;
    string tg = "R1";
    if (v) model(ln, k, tg);
    if (tag != "") tg = tag;
    req_valid = v;
    req_line  = LAW'(ln);
    @(negedge clk);
    n_vec++;
    if (rsp_valid !== v) begin
      n_bad++;
      $display("FAIL R1 rsp_valid actual %0b expected %0b", rsp_valid, v);
    end else if (v && rsp_kind !== 2'(k)) begin
      n_bad++;
      $display("FAIL %s/R2 line %0d rsp_kind actual %0d expected %0d", tg, ln, rsp_kind, k);
    end
  endtask

  initial begin
    for (int i = 0; i < DM; i++) begin m_vld[i] = 1'b0; m_line[i] = 0; end
    for (int i = 0; i < NC; i++) cnt[i] = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_line = '0;
    repeat (3) @(negedge clk);
    n_vec++;
    if (rsp_valid !== 1'b0) begin n_bad++; $display("FAIL R10 reset rsp_valid actual %0b expected 0", rsp_valid); end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: first access to an empty frame
    step(1, 0, "R10");
    step(1, 0, "R3");
    step(1, 64, "R6");
    step(1, 64, "R4");
    step(1, 64, "R4");
    step(1, 64, "R4");
    step(0, 0, "R1");
    step(1, 65, "R5");
    step(1, 1, "R6");
    // R7: saturate block 0 through repeated main hits
    for (int i = 0; i < 20; i++) step(1, 0, "R7");
    step(1, 128, "R7");
    for (int i = 1; i < 32; i++) step(1, 128 + i, "R7");
    step(1, 128, "R6");
    // R11: an aliasing block shares block 0's counter; R8: tie leaves it unchanged
    step(1, 32768, "R11");
    step(1, 32768, "R4");
    step(1, 32768 + 64, "R8");
    // R9: fill the buffer past capacity and revisit the oldest entries
    for (int i = 0; i < 40; i++) step(1, 64 * (100 + i), "R9");
    step(1, 64 * 100, "R9");
    step(1, 64 * 139, "R9");
    step(0, 0, "R1");
    // mixed stream over conflicting and aliasing blocks
    for (int i = 0; i < 3000; i++) begin
      int b = int'($urandom % 6);
      int unsigned bn = (b < 4) ? b : NC + b - 4;
      step(($urandom % 8) != 0, bn * BL + ($urandom % BL), "");
    end
    step(0, 0, "R1");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule